// File: doc/BRIEF.md
# Frequent pattern word compressor

The block takes one cache line as a stream of 32-bit words, one word per clock, and turns each word into a short token. A token has a 3-bit class code and a payload whose width depends on the class. Words that are small sign-extended integers, a halfword over a zero lower half, two sign-extended bytes, or four copies of one byte get short payloads. Any other word is passed through in full. Consecutive all-zero words are merged into a single run token.

Tokens leave the block in input order, at most one per cycle. Each token carries the running compressed size of its line, counted as class code plus payload bits. The final token of a line is marked, and it also reports whether the line came out larger than its uncompressed size and must be stored raw. Packing the tokens into memory, decompression and the storage policy are handled by neighbouring logic.

Top module: `fpc_line_compressor`

## Requirements
- R1: While reset is held, o_valid and o_raw are 0 and o_line_bits is 0.
- R2: Class codes and payload widths are: 0 zero run (3 bits, run length minus one), 1 four-bit sign-extended (4 bits, word[3:0]), 2 byte sign-extended (8 bits, word[7:0]), 3 halfword sign-extended (16 bits, word[15:0]), 4 upper halfword over a zero lower halfword (16 bits, word[31:16]), 5 two halfwords each sign-extended from a byte (16 bits, {word[23:16], word[7:0]}), 6 four identical bytes (8 bits, word[7:0]), 7 uncompressed (32 bits, the word). The payload is right-aligned in o_payload, the bits above it are 0, and o_len gives its width.
- R3: A nonzero word that fits several classes takes the class with the narrowest payload. Among classes of equal width, the lower class code wins.
- R4: A run of exactly one zero word is emitted as class 1 with payload 0.
- R5: Two to eight consecutive zero words in a line are emitted as one class 0 token with payload equal to the run length minus one. The zero that completes a run of eight closes that run, and any following zero starts a new run.
- R6: A pending zero run is emitted when a nonzero word arrives, and its token comes before that word's token. A pending zero run is also emitted when the line's final word is taken. Token order always follows word order.
- R7: o_valid is high only for a real token. A token is visible in the cycle after the edge at which the word that completes it is taken, unless a token held from the previous cycle goes out first. Cycles without a valid input never add tokens.
- R8: On every token, o_line_bits equals the sum of (3 + payload width) over the tokens of the current line, including this one. The sum restarts with the first token of the next line.
- R9: o_raw is 1 only on the final token of a line whose total from R8 exceeds LINE_WORDS*32 bits (512 by default).
- R10: o_last is 1 on exactly one token per line, the last one emitted for that line.
- R11: A word that fits no shorter class is emitted under class 7 with all 32 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_valid | input | 1 | Input word is valid this cycle |
| i_word | input | 32 | Uncompressed word |
| i_last | input | 1 | Marks the final word of the line |
| o_valid | output | 1 | Token is valid |
| o_prefix | output | 3 | Class code of the token |
| o_payload | output | 32 | Right-aligned payload |
| o_len | output | 6 | Payload width in bits |
| o_last | output | 1 | Final token of the line |
| o_line_bits | output | 10 | Running compressed size of the line in bits |
| o_raw | output | 1 | Line exceeds its uncompressed size (with the final token) |

## Verification
The bench targets the cycle where a nonzero word closes a pending run. In that cycle two tokens appear at once. A design that dropped or reordered one of them would lose a run or emit the word ahead of its zeros. The bench also covers runs that reach the cap of eight, a lone zero directly after a capped run, and a run closed by the line's final word. Errors there would show up as a wrong run length, a run coded as class 0 instead of class 1, or an o_last on the wrong token. Words that fit several classes, such as small negatives and values on the halfword and repeated-byte boundaries, would expose a wrong priority as a wider payload. All-uncompressed lines check that the raw flag rises past 512 bits and that the size sum restarts on the next line.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned PFX_W  = 3;
  localparam int unsigned LEN_W  = 6;

  typedef enum logic [PFX_W-1:0] {
    PFX_ZRUN     = 3'd0,
    PFX_SE4      = 3'd1,
    PFX_SE8      = 3'd2,
    PFX_SE16     = 3'd3,
    PFX_HIPAD    = 3'd4,
    PFX_BYTEPAIR = 3'd5,
    PFX_REPB     = 3'd6,
    PFX_RAW      = 3'd7
  } pfx_e;

  typedef struct packed {
    pfx_e               pfx;
    logic [WORD_W-1:0]  pay;
    logic [LEN_W-1:0]   len;
    logic               last;
  } tok_t;

  // Payload width per class; the run class width depends on the run cap.
  function automatic logic [LEN_W-1:0] payload_len(input pfx_e p, input int unsigned run_w);
    logic [LEN_W-1:0] l;
    case (p)
      PFX_ZRUN:     l = LEN_W'(run_w);
      PFX_SE4:      l = LEN_W'(4);
      PFX_SE8:      l = LEN_W'(8);
      PFX_REPB:     l = LEN_W'(8);
      PFX_SE16:     l = LEN_W'(16);
      PFX_HIPAD:    l = LEN_W'(16);
      PFX_BYTEPAIR: l = LEN_W'(16);
      default:      l = LEN_W'(WORD_W);
    endcase
    return l;
  endfunction

endpackage

// File: rtl/fpc_word_classifier.sv
module fpc_word_classifier
  import fpc_pkg::*;
#(
  parameter int unsigned RUN_W = 3
) (
  input  logic [WORD_W-1:0] word,
  output pfx_e              cls,
  output logic [WORD_W-1:0] pay,
  output logic [LEN_W-1:0]  len
);

  localparam int unsigned NBYTES = WORD_W / 8;

  logic [NBYTES-1:0] byte_same;
  logic fits_se4, fits_se8, fits_se16, fits_hipad, fits_pair, fits_rep;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_cmp
      assign byte_same[b] = (word[b*8 +: 8] == word[7:0]);
    end
  endgenerate

  always_comb begin
    fits_se4   = (word[WORD_W-1:3]  == {(WORD_W-3){word[3]}});
    fits_se8   = (word[WORD_W-1:7]  == {(WORD_W-7){word[7]}});
    fits_se16  = (word[WORD_W-1:15] == {(WORD_W-15){word[15]}});
    fits_hipad = (word[15:0] == 16'h0000);
    fits_pair  = (word[31:23] == {9{word[23]}}) && (word[15:7] == {9{word[7]}});
    fits_rep   = &byte_same;
  end

  // Ordered by payload width, then by class code among equal widths.
  always_comb begin
    if (fits_se4) begin
      cls = PFX_SE4;
      pay = WORD_W'(word[3:0]);
    end else if (fits_se8) begin
      cls = PFX_SE8;
      pay = WORD_W'(word[7:0]);
    end else if (fits_rep) begin
      cls = PFX_REPB;
      pay = WORD_W'(word[7:0]);
    end else if (fits_se16) begin
      cls = PFX_SE16;
      pay = WORD_W'(word[15:0]);
    end else if (fits_hipad) begin
      cls = PFX_HIPAD;
      pay = WORD_W'(word[31:16]);
    end else if (fits_pair) begin
      cls = PFX_BYTEPAIR;
      pay = WORD_W'({word[23:16], word[7:0]});
    end else begin
      cls = PFX_RAW;
      pay = word;
    end
    len = payload_len(cls, RUN_W);
  end

endmodule

// File: rtl/fpc_zero_run.sv
module fpc_zero_run
  import fpc_pkg::*;
#(
  parameter int unsigned RUN_MAX = 8,
  localparam int unsigned RUN_W  = $clog2(RUN_MAX),
  localparam int unsigned CNT_W  = $clog2(RUN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [WORD_W-1:0] i_word,
  input  logic              i_last,
  input  pfx_e              w_cls,
  input  logic [WORD_W-1:0] w_pay,
  input  logic [LEN_W-1:0]  w_len,
  output logic              a_v,
  output tok_t              a_tok,
  output logic              b_v,
  output tok_t              b_tok
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_inc;
  logic             is_zero;
  tok_t             word_tok;

  function automatic tok_t mk_run(input logic [CNT_W-1:0] c, input logic lst);
    tok_t t;
    t.last = lst;
    if (c == CNT_W'(1)) begin
      t.pfx = PFX_SE4;
      t.pay = '0;
    end else begin
      t.pfx = PFX_ZRUN;
      t.pay = WORD_W'(c - CNT_W'(1));
    end
    t.len = payload_len(t.pfx, RUN_W);
    return t;
  endfunction

  always_comb begin
    is_zero       = (i_word == '0);
    cnt_inc       = cnt_q + CNT_W'(1);
    word_tok.pfx  = w_cls;
    word_tok.pay  = w_pay;
    word_tok.len  = w_len;
    word_tok.last = i_last;
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    a_v    = 1'b0;
    b_v    = 1'b0;
    a_tok  = '0;
    b_tok  = '0;
    if (i_valid) begin
      cnt_en = 1'b1;
      if (is_zero) begin
        if ((cnt_inc == CNT_W'(RUN_MAX)) || i_last) begin
          a_v   = 1'b1;
          a_tok = mk_run(cnt_inc, i_last);
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        cnt_d = '0;
        if (cnt_q != '0) begin
          a_v   = 1'b1;
          a_tok = mk_run(cnt_q, 1'b0);
          b_v   = 1'b1;
          b_tok = word_tok;
        end else begin
          a_v   = 1'b1;
          a_tok = word_tok;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fpc_token_skid.sv
module fpc_token_skid
  import fpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_v,
  input  tok_t a_tok,
  input  logic b_v,
  input  tok_t b_tok,
  output logic out_v,
  output tok_t out_tok,
  output logic hold_v,
  output logic load_v,
  output tok_t load_tok
);

  tok_t hold_tok;
  logic hold_v_d;
  tok_t hold_tok_d;

  // The held token always leaves first; the older of the new ones follows it.
  always_comb begin
    if (hold_v) begin
      load_v     = 1'b1;
      load_tok   = hold_tok;
      hold_v_d   = a_v;
      hold_tok_d = a_tok;
    end else begin
      load_v     = a_v;
      load_tok   = a_tok;
      hold_v_d   = b_v;
      hold_tok_d = b_tok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      hold_v <= 1'b0;
    end else begin
      out_v  <= load_v;
      hold_v <= hold_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_tok <= '0;
    end else if (load_v) begin
      out_tok <= load_tok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_tok <= '0;
    end else if (hold_v_d) begin
      hold_tok <= hold_tok_d;
    end
  end

endmodule

// File: rtl/fpc_line_accum.sv
module fpc_line_accum
  import fpc_pkg::*;
#(
  parameter int unsigned ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_v,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_last,
  output logic [ACC_W-1:0] acc
);

  logic             fresh_q, fresh_d;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] base;

  always_comb begin
    base    = fresh_q ? '0 : acc;
    acc_d   = base + ACC_W'(PFX_W) + ACC_W'(load_len);
    fresh_d = load_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      fresh_q <= 1'b1;
    end else if (load_v) begin
      acc     <= acc_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/fpc_line_compressor.sv
module fpc_line_compressor
  import fpc_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 16,
  parameter int unsigned RUN_MAX    = 8,
  localparam int unsigned RUN_W     = $clog2(RUN_MAX),
  localparam int unsigned RAW_LIMIT = LINE_WORDS * WORD_W,
  localparam int unsigned ACC_W     = $clog2(LINE_WORDS * (WORD_W + PFX_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [WORD_W-1:0] i_word,
  input  logic              i_last,
  output logic              o_valid,
  output logic [PFX_W-1:0]  o_prefix,
  output logic [WORD_W-1:0] o_payload,
  output logic [LEN_W-1:0]  o_len,
  output logic              o_last,
  output logic [ACC_W-1:0]  o_line_bits,
  output logic              o_raw
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  pfx_e              w_cls;
  logic [WORD_W-1:0] w_pay;
  logic [LEN_W-1:0]  w_len;
  logic              pair_a_v, pair_b_v;
  tok_t              pair_a_tok, pair_b_tok;
  logic              out_v, hold_v, load_v;
  tok_t              out_tok, load_tok;
  logic [ACC_W-1:0]  acc;

  fpc_word_classifier #(.RUN_W(RUN_W)) u_cls (
    .word (i_word),
    .cls  (w_cls),
    .pay  (w_pay),
    .len  (w_len)
  );

  fpc_zero_run #(.RUN_MAX(RUN_MAX)) u_run (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .i_valid (i_valid),
    .i_word  (i_word),
    .i_last  (i_last),
    .w_cls   (w_cls),
    .w_pay   (w_pay),
    .w_len   (w_len),
    .a_v     (pair_a_v),
    .a_tok   (pair_a_tok),
    .b_v     (pair_b_v),
    .b_tok   (pair_b_tok)
  );

  fpc_token_skid u_skid (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .a_v      (pair_a_v),
    .a_tok    (pair_a_tok),
    .b_v      (pair_b_v),
    .b_tok    (pair_b_tok),
    .out_v    (out_v),
    .out_tok  (out_tok),
    .hold_v   (hold_v),
    .load_v   (load_v),
    .load_tok (load_tok)
  );

  fpc_line_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_v    (load_v),
    .load_len  (load_tok.len),
    .load_last (load_tok.last),
    .acc       (acc)
  );

  always_comb begin
    o_valid     = out_v;
    o_prefix    = out_tok.pfx;
    o_payload   = out_tok.pay;
    o_len       = out_tok.len;
    o_last      = out_v & out_tok.last;
    o_line_bits = acc;
    o_raw       = out_v & out_tok.last & (acc > ACC_W'(RAW_LIMIT));
  end

endmodule

// File: rtl/fpc_line_compressor_chk.sv
module fpc_line_compressor_chk #(
  parameter int unsigned RUN_MAX = 8,
  parameter int unsigned ACC_W   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_valid,
  input logic [31:0]      i_word,
  input logic             o_valid,
  input logic [2:0]       o_prefix,
  input logic [31:0]      o_payload,
  input logic [5:0]       o_len,
  input logic             o_last,
  input logic [ACC_W-1:0] o_line_bits,
  input logic             o_raw,
  input logic             hold_v,
  input logic             b_v
);

  localparam int unsigned RUN_W = $clog2(RUN_MAX);

  // R2: width follows the class code
  a_r2_len_map: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_len == ((o_prefix == 3'd0) ? 6'(RUN_W) :
                          (o_prefix == 3'd1) ? 6'd4 :
                          (o_prefix == 3'd2 || o_prefix == 3'd6) ? 6'd8 :
                          (o_prefix == 3'd7) ? 6'd32 : 6'd16));

  // R3, R11: an uncompressed word could not have used a shorter class
  a_r3_raw_not_shorter: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_prefix == 3'd7) |->
      (o_payload[31:15] != {17{o_payload[15]}}) &&
      !(o_payload[31:24] == o_payload[7:0] && o_payload[23:16] == o_payload[7:0] &&
        o_payload[15:8] == o_payload[7:0]));

  // R4: four-bit class never carries bits above its field
  a_r4_se4_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_prefix == 3'd1) |-> o_payload[31:4] == 28'd0);

  // R5: a run token stands for two to RUN_MAX zeros
  a_r5_run_range: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_prefix == 3'd0) |-> (o_payload != 32'd0) && (o_payload < 32'(RUN_MAX)));

  // R6: a second token is never produced while the spare slot is occupied
  a_r6_no_lost_token: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> !b_v);

  // R7: a nonzero word always yields a token on the next cycle
  a_r7_word_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_word != 32'd0) |=> o_valid);

  // R7: no input and nothing held means nothing next cycle
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_valid && !hold_v) |=> !o_valid);

  // R8: the size sum grows within a line
  a_r8_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_last) |=> (!o_valid || (o_line_bits > $past(o_line_bits))));

  // R9: raw flag only with the final token
  a_r9_raw_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    o_raw |-> (o_valid && o_last));

endmodule

bind fpc_line_compressor fpc_line_compressor_chk #(
  .RUN_MAX (RUN_MAX),
  .ACC_W   (ACC_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .i_valid     (i_valid),
  .i_word      (i_word),
  .o_valid     (o_valid),
  .o_prefix    (o_prefix),
  .o_payload   (o_payload),
  .o_len       (o_len),
  .o_last      (o_last),
  .o_line_bits (o_line_bits),
  .o_raw       (o_raw),
  .hold_v      (hold_v),
  .b_v         (pair_b_v)
);

// File: tb/fpc_line_compressor_tb_top.sv
module fpc_line_compressor_tb_top;

  localparam int ACC_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             i_valid;
  logic [31:0]      i_word;
  logic             i_last;
  logic             o_valid;
  logic [2:0]       o_prefix;
  logic [31:0]      o_payload;
  logic [5:0]       o_len;
  logic             o_last;
  logic [ACC_W-1:0] o_line_bits;
  logic             o_raw;

  always #5 clk = ~clk;

  fpc_line_compressor dut_i (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_word(i_word), .i_last(i_last),
    .o_valid(o_valid), .o_prefix(o_prefix), .o_payload(o_payload), .o_len(o_len),
    .o_last(o_last), .o_line_bits(o_line_bits), .o_raw(o_raw)
  );

  typedef struct {
    int          pfx;
    logic [31:0] pay;
    int          len;
    bit          last;
  } mtok_t;

  mtok_t q[$];
  mtok_t exp_t;
  bit    exp_v;
  int    zcount;
  int    m_acc;
  bit    m_fresh;
  bit    cmp_en;
  bit    done;
  int    n_chk;
  int    n_fail;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic void classify(input logic [31:0] w, output mtok_t t);
    int best;
    best  = 33;
    t.pfx = 7; t.pay = w; t.len = 32; t.last = 0;
    for (int c = 1; c <= 6; c++) begin
      bit ok; int l; logic [31:0] p;
      ok = 0; l = 0; p = 0;
      case (c)
        1: begin ok = ($signed(w) >= -8 && $signed(w) <= 7); l = 4; p = w & 32'hF; end
        2: begin ok = ($signed(w) >= -128 && $signed(w) <= 127); l = 8; p = w & 32'hFF; end
        3: begin ok = ($signed(w) >= -32768 && $signed(w) <= 32767); l = 16; p = w & 32'hFFFF; end
        4: begin ok = (w[15:0] == 0); l = 16; p = w >> 16; end
        5: begin
             ok = ($signed(w[31:16]) >= -128 && $signed(w[31:16]) <= 127 &&
                   $signed(w[15:0]) >= -128 && $signed(w[15:0]) <= 127);
             l = 16; p = {16'h0, w[23:16], w[7:0]};
           end
        default: begin
             ok = 1;
             for (int k = 1; k < 4; k++) if (w[k*8 +: 8] != w[7:0]) ok = 0;
             l = 8; p = w & 32'hFF;
           end
      endcase
      if (ok && l < best) begin best = l; t.pfx = c; t.pay = p; t.len = l; end
    end
  endfunction

  function automatic mtok_t run_tok(input int n, input bit lst);
    mtok_t t;
    t.last = lst;
    if (n == 1) begin t.pfx = 1; t.pay = 0; t.len = 4; end
    else        begin t.pfx = 0; t.pay = n - 1; t.len = 3; end
    return t;
  endfunction

  // Reference model, advanced once per rising edge.
  always @(posedge clk) begin
    if (cmp_en) begin
      if (i_valid) begin
        if (i_word == 0) begin
          zcount++;
          if (zcount == 8 || i_last) begin q.push_back(run_tok(zcount, i_last)); zcount = 0; end
        end else begin
          mtok_t t;
          if (zcount > 0) begin q.push_back(run_tok(zcount, 0)); zcount = 0; end
          classify(i_word, t);
          t.last = i_last;
          q.push_back(t);
        end
      end
      if (q.size() > 0) begin
        exp_t   = q.pop_front();
        exp_v   = 1;
        m_acc   = (m_fresh ? 0 : m_acc) + 3 + exp_t.len;
        m_fresh = exp_t.last;
      end else begin
        exp_v = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(o_valid == exp_v, "R6/R7", "o_valid", o_valid, exp_v);
      if (exp_v && o_valid) begin
        string tag;
        if (exp_t.pfx == 0)      tag = "R5";
        else if (exp_t.pfx == 1 && exp_t.pay == 0) tag = "R4";
        else if (exp_t.pfx == 7) tag = "R11";
        else                     tag = "R3";
        chk(o_prefix == 3'(exp_t.pfx), tag, "o_prefix", o_prefix, exp_t.pfx);
        chk(o_payload == exp_t.pay, "R2", "o_payload", o_payload, exp_t.pay);
        chk(o_len == 6'(exp_t.len), "R2", "o_len", o_len, exp_t.len);
        chk(o_last == exp_t.last, "R10", "o_last", o_last, exp_t.last);
        chk(o_line_bits == ACC_W'(m_acc), "R8", "o_line_bits", o_line_bits, m_acc);
        chk(o_raw == (exp_t.last && m_acc > 512), "R9", "o_raw", o_raw,
            (exp_t.last && m_acc > 512));
      end else if (!exp_v) begin
        chk(o_raw == 1'b0, "R9", "o_raw idle", o_raw, 0);
      end
    end
  end

  task automatic send(input logic [31:0] w, input bit l);
    i_valid = 1'b1; i_word = w; i_last = l;
    @(negedge clk);
    i_valid = 1'b0; i_last = 1'b0;
  endtask

  task automatic send_fill(input logic [31:0] w, input int n, input bit end_line);
    for (int k = 0; k < n; k++) send(w, end_line && (k == n - 1));
  endtask

  function automatic logic [31:0] pick_word();
    int r;
    logic [7:0] b;
    r = $urandom_range(0, 10);
    b = 8'($urandom);
    case (r)
      0, 1, 2, 3: return 32'h0;
      4: return 32'($signed(4'($urandom)));
      5: return 32'($signed(b));
      6: return {b, b, b, b};
      7: return 32'($signed(16'($urandom)));
      8: return {16'($urandom), 16'h0};
      9: return {{8{b[7]}}, b, {8{b[0]}}, b[0], b[6:0]};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          done = 1;
          n_chk++; n_fail++;
          $display("FAIL watchdog expired");
          $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
          $finish;
        end
      end
    join_none
  end

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; i_word = '0; i_last = 1'b0;
    zcount = 0; m_acc = 0; m_fresh = 1; cmp_en = 0; done = 0; exp_v = 0;
    n_chk = 0; n_fail = 0;
    repeat (3) @(negedge clk);
    chk(o_valid == 1'b0, "R1", "o_valid in reset", o_valid, 0);
    chk(o_line_bits == '0, "R1", "o_line_bits in reset", o_line_bits, 0);
    chk(o_raw == 1'b0, "R1", "o_raw in reset", o_raw, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    // R5: all-zero line, two capped runs
    send_fill(32'h0, 16, 1);
    // R3, R11: one of each class, a lone zero and a short run
    send(32'h0000_0005, 0); send(32'hFFFF_FFF9, 0); send(32'h0000_007F, 0);
    send(32'hFFFF_FF80, 0); send(32'h4141_4141, 0); send(32'h0000_1234, 0);
    send(32'hABCD_0000, 0); send(32'h0005_FFFD, 0); send(32'hDEAD_BEEF, 0);
    send(32'h0, 0); send(32'h0000_0003, 0); send(32'h0, 0); send(32'h0, 0);
    send(32'h0, 0); send(32'hFFFF_8000, 0); send(32'h0000_8000, 1);
    repeat (2) @(negedge clk);
    // R9: all uncompressed, then a short line to restart the sum (R8)
    for (int k = 0; k < 16; k++) send(32'h1234_5678 + 32'(k), k == 15);
    send_fill(32'h0000_0001, 16, 1);
    // R6: fifteen zeros then a nonzero final word, two tokens at once
    send_fill(32'h0, 15, 0); send(32'h8765_4321, 1);
    // R4: nine zeros (capped run plus lone zero) then nonzero words
    send_fill(32'h0, 9, 0); send_fill(32'h0000_0100, 7, 1);
    // R4, R6: lone zero closed by the final word
    send_fill(32'h7777_7777, 15, 0); send(32'h0, 1);
    // R6: short run closed by the final word
    send_fill(32'h0000_0002, 13, 0); send_fill(32'h0, 3, 1);
    // Randomized lines with gaps
    for (int ln = 0; ln < 40; ln++) begin
      for (int k = 0; k < 16; k++) begin
        send(pick_word(), k == 15);
        if ($urandom_range(0, 3) == 0) @(negedge clk);
      end
    end
    repeat (10) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule